// File: doc/BRIEF.md
# Transfer Channel Completion Controller

This block tracks when fifteen interrupt-driven transfer channels run out of work. Every channel belongs to one interrupt source and has three pieces of state: a select bit that software sets to arm the channel, a transfer count that software loads, and a pending bit that only hardware changes. Each time the transfer engine handles an interrupt for an armed channel, it pulses that channel's serviced input, and the channel's count drops by one.

When a count goes from one to zero, the block disarms the channel by clearing its select bit. In the same cycle it sets the channel's pending bit. A set pending bit is a request for a final end-of-transfer interrupt on the source's ordinary interrupt vector. The block presents the highest-numbered pending request, with its vector address and a valid flag. The CPU acknowledges a request by index, and the acknowledge clears that pending bit. Hardware never arms a channel again: software must write the select bit to restart it.

Software reaches the state through one register port with a combinational read. Address 0 holds the select bits, address 1 holds the pending bits, and address 16+i holds the count of channel i.

Top module: `xfer_done_ctrl`

## Requirements
- R1: After reset, the select register, the pending register and every count read 0, and `req_valid` is 0.
- R2: A serviced pulse on a channel that is selected and has a count above 1 lowers the count by exactly one. It leaves the select and pending bits unchanged.
- R3: A serviced pulse on a selected channel whose count is 1 makes the count 0. At the same clock edge it clears the channel's select bit and sets its pending bit.
- R4: A serviced pulse has no effect on a channel whose select bit is clear, or on one whose count is already 0. The count does not wrap below zero.
- R5: Writes to address 1 (pending) are ignored. Bit 15 reads 0 at addresses 0 and 1. A write to address 0 loads bits 14:0 into the select bits.
- R6: An acknowledge with index i below 15 clears pending bit i at the next edge. An acknowledge with an index of 15 changes nothing.
- R7: If a pending bit is set by a zero-count event and acknowledged in the same cycle, the bit ends up set.
- R8: `req_valid` is 1 exactly when some pending bit is set. `req_idx` is then the highest-numbered set bit, and `req_vec` equals 2040H + 2*`req_idx`.
- R9: A select bit changes from 0 to 1 only through a software write to address 0. Later serviced pulses never re-arm a disarmed channel.
- R10: A write to address 16+i loads the 8-bit count of channel i from bits 7:0, and a read of that address returns it zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| xfer_done | input | 15 | Per-channel transfer-serviced pulse |
| ack | input | 1 | End-of-transfer acknowledge |
| ack_idx | input | 4 | Index of the acknowledged source |
| req_valid | output | 1 | Some end-of-transfer request is pending |
| req_idx | output | 4 | Index of the highest pending request |
| req_vec | output | 16 | Vector address of that request |

## Verification
The assertions check several properties on every cycle:
- A pending bit rises only after a serviced pulse on a selected channel.
- A select bit rises only after a write to address 0.
- An acknowledge without a competing event leaves the bit clear.
- The request outputs agree with the pending set, and bit 15 reads zero.

Only the bench's scenarios show the following:
- Exact count arithmetic, including the absence of underflow at zero.
- Priority order as several requests are acknowledged in turn.
- The set-beats-acknowledge collision.

These depend on loaded counts and event order.

// File: rtl/xfer_done_ctrl.sv
module xfer_done_ctrl #(
  parameter int NCH = 15,
  parameter int CW = 8,
  parameter int IW = 4,
  parameter int AW = 5,
  parameter logic [15:0] VEC_BASE = 16'h2040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic [NCH-1:0] xfer_done,
  input  logic          ack,
  input  logic [IW-1:0] ack_idx,
  output logic          req_valid,
  output logic [IW-1:0] req_idx,
  output logic [15:0]   req_vec
);
  localparam int SEL_A = 0;
  localparam int PEND_A = 1;
  localparam int CNT_A = 16;

  logic [NCH-1:0] sel, pend, live, hit, ack_mask;
  logic [CW-1:0]  cnt [NCH];

  wire sel_wr = reg_we && (reg_addr == AW'(SEL_A));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign live[i]     = xfer_done[i] & sel[i] & (cnt[i] != '0);
    assign hit[i]      = live[i] & (cnt[i] == CW'(1));
    assign ack_mask[i] = ack & (ack_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (live[i])
        cnt[i] <= cnt[i] - CW'(1);
      else if (reg_we && reg_addr == AW'(CNT_A + i))
        cnt[i] <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      pend <= '0;
    end else begin
      sel  <= (sel_wr ? reg_wdata[NCH-1:0] : sel) & ~hit;
      pend <= (pend & ~ack_mask) | hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(SEL_A))  reg_rdata = 16'(sel);
    if (reg_addr == AW'(PEND_A)) reg_rdata = 16'(pend);
    for (int i = 0; i < NCH; i++)
      if (reg_addr == AW'(CNT_A + i)) reg_rdata = 16'(cnt[i]);
  end

  always_comb begin
    req_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (pend[i]) req_idx = IW'(i);
  end

  assign req_valid = |pend;
  assign req_vec   = VEC_BASE + (16'(req_idx) << 1);
endmodule

// File: rtl/xfer_done_ctrl_chk.sv
module xfer_done_ctrl_chk #(
  parameter int NCH = 15,
  parameter int IW = 4,
  parameter int AW = 5,
  parameter logic [15:0] VEC_BASE = 16'h2040
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [AW-1:0]  reg_addr,
  input logic [15:0]    reg_rdata,
  input logic [NCH-1:0] xfer_done,
  input logic           ack,
  input logic [IW-1:0]  ack_idx,
  input logic           req_valid,
  input logic [IW-1:0]  req_idx,
  input logic [15:0]    req_vec,
  input logic [NCH-1:0] sel,
  input logic [NCH-1:0] pend
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r3_pend_needs_service: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(sel[i] && xfer_done[i]));
    a_r9_sel_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel[i]) |-> $past(reg_we && reg_addr == AW'(0)));
  end

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int'(ack_idx) < NCH && !xfer_done[ack_idx]) |=> !pend[$past(ack_idx)]);

  a_r8_valid_matches: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (pend != '0));

  a_r8_highest_idx: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((pend >> req_idx) == NCH'(1)));

  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_vec - VEC_BASE) == {11'd0, req_idx, 1'b0});

  a_r5_bit15_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(0) || reg_addr == AW'(1)) |-> !reg_rdata[15]);
endmodule

bind xfer_done_ctrl xfer_done_ctrl_chk #(.NCH(NCH), .IW(IW), .AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .xfer_done(xfer_done), .ack(ack), .ack_idx(ack_idx), .req_valid(req_valid),
  .req_idx(req_idx), .req_vec(req_vec), .sel(sel), .pend(pend)
);

// File: tb/tb_xfer_done_ctrl.sv
module tb_xfer_done_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [14:0] xfer_done = 0;
  logic ack = 0;
  logic [3:0] ack_idx = 0;
  logic req_valid;
  logic [3:0] req_idx;
  logic [15:0] req_vec;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_done_ctrl dut (.*);

  task automatic check(string r, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(logic [14:0] m, logic a, logic [3:0] ai);
    @(negedge clk); xfer_done = m; ack = a; ack_idx = ai;
    @(negedge clk); xfer_done = 0; ack = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); check("R1 sel", v, 0);
    rd(1, v); check("R1 pend", v, 0);
    for (int i = 0; i < 15; i++) begin rd(5'(16 + i), v); check("R1 cnt", v, 0); end
    check("R1 req_valid", 16'(req_valid), 0);

    wr(1, 16'hFFFF); rd(1, v); check("R5 pend write ignored", v, 0);
    wr(0, 16'hFFFF); rd(0, v); check("R5 sel bit15 zero", v, 16'h7FFF);
    wr(0, 0);
    wr(16, 16'h12A5); rd(16, v); check("R10 count load 8 bits", v, 16'h00A5);

    for (int ch = 0; ch < 15; ch++) begin
      for (int k = 1; k <= 3; k++) begin
        wr(5'(16 + ch), 16'(k));
        wr(0, 16'(1 << ch));
        for (int p = k - 1; p >= 1; p--) begin
          pulse(15'(1 << ch), 0, 0);
          rd(5'(16 + ch), v); check("R2 decrement", v, 16'(p));
          rd(1, v); check("R2 pend unchanged", v, 0);
          rd(0, v); check("R2 sel kept", v, 16'(1 << ch));
        end
        pulse(15'(1 << ch), 0, 0);
        rd(5'(16 + ch), v); check("R3 count zero", v, 0);
        rd(0, v); check("R3 sel cleared", v, 0);
        rd(1, v); check("R3 pend set", v, 16'(1 << ch));
        check("R8 valid", 16'(req_valid), 1);
        check("R8 idx", 16'(req_idx), 16'(ch));
        check("R8 vec", req_vec, 16'h2040 + 16'(2 * ch));
        pulse(15'(1 << ch), 0, 0);
        rd(5'(16 + ch), v); check("R4 no underflow", v, 0);
        rd(0, v); check("R9 not re-armed", v, 0);
        pulse(0, 1, 4'(ch));
        rd(1, v); check("R6 ack clears", v, 0);
        check("R8 valid low", 16'(req_valid), 0);
      end
    end

    // selected with zero count: no effect
    wr(0, 16'h0010); pulse(15'h0010, 0, 0);
    rd(1, v); check("R4 zero count no pend", v, 0);
    rd(0, v); check("R4 zero count sel kept", v, 16'h0010);
    wr(0, 0);
    wr(5'(16 + 6), 5); pulse(15'h0040, 0, 0);
    rd(5'(16 + 6), v); check("R4 unselected cnt", v, 5);
    rd(1, v); check("R4 unselected pend", v, 0);

    wr(5'(16 + 3), 1); wr(5'(16 + 7), 1); wr(5'(16 + 12), 1);
    wr(0, 16'h1088);
    pulse(15'h1088, 0, 0);
    rd(1, v); check("R3 multi pend", v, 16'h1088);
    check("R8 prio 12", 16'(req_idx), 12);
    pulse(0, 1, 15);
    rd(1, v); check("R6 idx 15 ignored", v, 16'h1088);
    pulse(0, 1, 12); check("R8 prio 7", 16'(req_idx), 7);
    check("R8 vec 7", req_vec, 16'h204E);
    pulse(0, 1, 7); check("R8 prio 3", 16'(req_idx), 3);
    pulse(0, 1, 3); check("R8 none", 16'(req_valid), 0);

    wr(5'(16 + 5), 1); wr(0, 16'h0020); pulse(15'h0020, 0, 0);
    wr(5'(16 + 5), 1); wr(0, 16'h0020);
    pulse(15'h0020, 1, 5);
    rd(1, v); check("R7 set wins", v, 16'h0020);
    pulse(0, 1, 5);
    rd(1, v); check("R6 plain ack", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule